// File: doc/BRIEF.md
# Processor mode and stack-pointer controller

This block holds the execution context of a small processor core. It tracks whether the core runs ordinary application code (Thread mode) or services an exception (Handler mode). It also tracks whether code is privileged and which of two banked stack pointers is live: the main stack or the process stack. A two-bit control register sets privilege and stack choice for Thread mode. Bit 0 high makes Thread code unprivileged. Bit 1 high selects the process stack. Software writes to this register carry the writer's privilege and pass through filters that depend on mode and privilege.

Exception entry and return are single-cycle strobes from the core's sequencer. On entry the block presents the 32-bit return code that the core must save. On return it decodes the code given back, restores mode and stack, and checks the code against its count of nested exceptions. It raises a one-cycle fault for a code that does not fit. A parameter chooses between a full 32-bit compare of return codes and a cheaper compare of the low nibble only.

Top module: `proc_mode_ctrl`

## Requirements
- R1: After reset the block is in Thread mode (`mode_handler`=0), privileged (`priv_eff`=1), on the main stack (`use_psp`=0), with both control bits 0 and `ret_fault`=0.
- R2: In Thread mode, `priv_eff` is the inverse of control bit 0, and an accepted write of bit 0 shows on `priv_eff` after the next clock edge.
- R3: In Thread mode, `use_psp` equals control bit 1, and an accepted write of bit 1 shows on `use_psp` after the next clock edge.
- R4: In Handler mode `priv_eff`=1 and `use_psp`=0 whatever the control bits hold, and a write to bit 1 made in Handler mode is ignored. Bit 0 is still written.
- R5: A control write with `ctl_wr_priv`=0 changes neither control bit.
- R6: An entry strobe moves the block to Handler mode, privileged, on the main stack. It clears control bit 1 and raises the nesting count by one, saturating at its maximum.
- R7: During the entry cycle `entry_code` is 0xFFFFFFF1 if the block is in Handler mode, 0xFFFFFFF9 if it is in Thread mode on the main stack, and 0xFFFFFFFD if it is in Thread mode on the process stack.
- R8: A valid return with code 0xFFFFFFF9 goes to Thread mode on the main stack, and 0xFFFFFFFD goes to Thread mode on the process stack. Control bit 1 is set to match the stack, and the nesting count falls by one.
- R9: A return is bad if its code is not one of 0xFFFFFFF1, 0xFFFFFFF9, 0xFFFFFFFD. It is also bad if it arrives with a nesting count of zero, or if it targets Thread mode while the count after the decrement would stay above zero. A bad return raises `ret_fault` for exactly the cycle after the strobe and leaves mode, stack and control bits unchanged.
- R10: Priority within one cycle is entry first, then return, then control write. A write that shares its cycle with either strobe is dropped.
- R11: A return with code 0xFFFFFFF1 is valid only with a nesting count above one. It leaves the block in Handler mode on the main stack with the count reduced by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_wr_en | input | 1 | Software write to the control register |
| ctl_wr_data | input | 2 | Write value: bit 0 unprivileged-thread, bit 1 process-stack |
| ctl_wr_priv | input | 1 | Privilege of the writing code, 1 = privileged |
| exc_entry | input | 1 | Exception entry strobe |
| exc_return | input | 1 | Exception return strobe |
| exc_ret_code | input | 32 | Return code presented with `exc_return` |
| mode_handler | output | 1 | 1 = Handler mode, 0 = Thread mode |
| priv_eff | output | 1 | Effective privilege of executing code |
| use_psp | output | 1 | 1 = process stack active, 0 = main stack |
| entry_code | output | 32 | Return code to save on exception entry |
| ret_fault | output | 1 | One-cycle flag for a rejected return |

## Verification
The hardest case to reach from the ports is a return whose code is well formed but does not fit the nesting depth. One example is a return to Thread mode while a second exception is still open. Another is a return from Thread mode with no exception open. The stimulus builds a two-deep nest by entering from Thread mode on the process stack and then entering again from Handler mode. Against that state it issues a premature Thread return, then a malformed code, then an unwind through a Handler return. It then issues one more return after the nest is empty. A reference model in the bench checks each step. The bench also drives entry and a control write together, and return and a control write together, to check which one takes effect.

// File: rtl/pmsc_pkg.sv
package pmsc_pkg;

   typedef enum logic {
      MODE_THREAD  = 1'b0,
      MODE_HANDLER = 1'b1
   } xmode_e;

   typedef enum logic [1:0] {
      RT_NONE    = 2'd0,
      RT_HANDLER = 2'd1,
      RT_TMAIN   = 2'd2,
      RT_TPROC   = 2'd3
   } rtgt_e;

   localparam logic [31:0] RC_HANDLER     = 32'hFFFF_FFF1;
   localparam logic [31:0] RC_THREAD_MAIN = 32'hFFFF_FFF9;
   localparam logic [31:0] RC_THREAD_PROC = 32'hFFFF_FFFD;

endpackage

// File: rtl/pmsc_ret_decode.sv
module pmsc_ret_decode
   import pmsc_pkg::*;
#(
   parameter int FULL_DECODE = 1
) (
   input  logic [31:0] code,
   output rtgt_e       tgt
);

   generate
      if (FULL_DECODE != 0) begin : g_full
         always_comb begin
            unique case (code)
               RC_HANDLER:     tgt = RT_HANDLER;
               RC_THREAD_MAIN: tgt = RT_TMAIN;
               RC_THREAD_PROC: tgt = RT_TPROC;
               default:        tgt = RT_NONE;
            endcase
         end
      end else begin : g_nibble
         logic [27:0] unused_hi;
         assign unused_hi = code[31:4];
         always_comb begin
            unique case (code[3:0])
               RC_HANDLER[3:0]:     tgt = RT_HANDLER;
               RC_THREAD_MAIN[3:0]: tgt = RT_TMAIN;
               RC_THREAD_PROC[3:0]: tgt = RT_TPROC;
               default:             tgt = RT_NONE;
            endcase
         end
      end
   endgenerate

endmodule

// File: rtl/pmsc_exc_seq.sv
module pmsc_exc_seq
   import pmsc_pkg::*;
#(
   parameter int NEST_W      = 4,
   parameter int FULL_DECODE = 1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        entry,
   input  logic        ret,
   input  logic [31:0] ret_code,
   output xmode_e      mode,
   output logic        ret_ok,
   output logic        ret_psp,
   output logic        fault
);

   localparam logic [NEST_W-1:0] NEST_MAX = {NEST_W{1'b1}};
   localparam logic [NEST_W-1:0] NEST_ONE = NEST_W'(1);

   rtgt_e             tgt;
   logic [NEST_W-1:0] nest_q;
   logic              depth_fit;
   xmode_e            mode_q;
   logic              fault_q;

   pmsc_ret_decode #(.FULL_DECODE(FULL_DECODE)) u_dec (
      .code (ret_code),
      .tgt  (tgt)
   );

   always_comb begin
      unique case (tgt)
         RT_HANDLER:         depth_fit = (nest_q > NEST_ONE);
         RT_TMAIN, RT_TPROC: depth_fit = (nest_q == NEST_ONE);
         default:            depth_fit = 1'b0;
      endcase
   end

   assign ret_ok  = ret && !entry && depth_fit;
   assign ret_psp = (tgt == RT_TPROC);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nest_q  <= '0;
         mode_q  <= MODE_THREAD;
         fault_q <= 1'b0;
      end else begin
         fault_q <= ret && !entry && !depth_fit;
         if (entry) begin
            mode_q <= MODE_HANDLER;
            if (nest_q != NEST_MAX) nest_q <= nest_q + NEST_ONE;
         end else if (ret_ok) begin
            nest_q <= nest_q - NEST_ONE;
            mode_q <= (tgt == RT_HANDLER) ? MODE_HANDLER : MODE_THREAD;
         end
      end
   end

   assign mode  = mode_q;
   assign fault = fault_q;

   // R6
   entry_hdl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      entry |=> (mode_q == MODE_HANDLER));

   // R9
   fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ret && !entry && !depth_fit) |=> ($stable(nest_q) && $stable(mode_q)));

   // R9
   fault_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_q |-> $past(ret && !entry));

   // R11
   nest_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_THREAD) == (nest_q == '0));

endmodule

// File: rtl/pmsc_ctrl_reg.sv
module pmsc_ctrl_reg
   import pmsc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       entry,
   input  logic       ret_strobe,
   input  logic       ret_ok,
   input  logic       ret_psp,
   input  logic       wr_en,
   input  logic [1:0] wr_data,
   input  logic       wr_priv,
   input  xmode_e     mode,
   output logic [1:0] ctrl
);

   logic [1:0] ctrl_q;
   logic       wr_take;

   assign wr_take = wr_en && wr_priv && !entry && !ret_strobe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= 2'b00;
      end else if (entry) begin
         ctrl_q[1] <= 1'b0;
      end else if (ret_ok) begin
         ctrl_q[1] <= ret_psp;
      end else if (wr_take) begin
         ctrl_q[0] <= wr_data[0];
         if (mode == MODE_THREAD) ctrl_q[1] <= wr_data[1];
      end
   end

   assign ctrl = ctrl_q;

   // R5
   unpriv_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_priv && !entry && !ret_ok) |=> $stable(ctrl_q));

   // R4
   hdl_msp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_HANDLER) |-> !ctrl_q[1]);

   // R3
   psp_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_take && mode == MODE_THREAD && wr_data[1]) |=> ctrl_q[1]);

   // R10
   entry_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (entry && wr_en) |=> ($stable(ctrl_q[0]) && !ctrl_q[1]));

endmodule

// File: rtl/pmsc_view.sv
module pmsc_view
   import pmsc_pkg::*;
(
   input  xmode_e      mode,
   input  logic [1:0]  ctrl,
   output logic        mode_handler,
   output logic        priv_eff,
   output logic        use_psp,
   output logic [31:0] entry_code
);

   assign mode_handler = (mode == MODE_HANDLER);
   assign priv_eff     = mode_handler || !ctrl[0];
   assign use_psp      = !mode_handler && ctrl[1];

   always_comb begin
      if (mode_handler)  entry_code = RC_HANDLER;
      else if (ctrl[1])  entry_code = RC_THREAD_PROC;
      else               entry_code = RC_THREAD_MAIN;
   end

endmodule

// File: rtl/proc_mode_ctrl.sv
module proc_mode_ctrl
   import pmsc_pkg::*;
#(
   parameter int NEST_W      = 4,
   parameter int FULL_DECODE = 1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        ctl_wr_en,
   input  logic [1:0]  ctl_wr_data,
   input  logic        ctl_wr_priv,
   input  logic        exc_entry,
   input  logic        exc_return,
   input  logic [31:0] exc_ret_code,
   output logic        mode_handler,
   output logic        priv_eff,
   output logic        use_psp,
   output logic [31:0] entry_code,
   output logic        ret_fault
);

   generate
      if (NEST_W < 1 || NEST_W > 8) begin : g_bad_nest
         $error("proc_mode_ctrl: NEST_W must lie in 1..8");
      end
      if (FULL_DECODE != 0 && FULL_DECODE != 1) begin : g_bad_dec
         $error("proc_mode_ctrl: FULL_DECODE must be 0 or 1");
      end
   endgenerate

   xmode_e     mode;
   logic       ret_ok;
   logic       ret_psp;
   logic [1:0] ctrl;

   pmsc_exc_seq #(.NEST_W(NEST_W), .FULL_DECODE(FULL_DECODE)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .entry    (exc_entry),
      .ret      (exc_return),
      .ret_code (exc_ret_code),
      .mode     (mode),
      .ret_ok   (ret_ok),
      .ret_psp  (ret_psp),
      .fault    (ret_fault)
   );

   pmsc_ctrl_reg u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .entry      (exc_entry),
      .ret_strobe (exc_return),
      .ret_ok     (ret_ok),
      .ret_psp    (ret_psp),
      .wr_en      (ctl_wr_en),
      .wr_data    (ctl_wr_data),
      .wr_priv    (ctl_wr_priv),
      .mode       (mode),
      .ctrl       (ctrl)
   );

   pmsc_view u_view (
      .mode         (mode),
      .ctrl         (ctrl),
      .mode_handler (mode_handler),
      .priv_eff     (priv_eff),
      .use_psp      (use_psp),
      .entry_code   (entry_code)
   );

   // R8
   ret_thread_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_ok && exc_ret_code == RC_THREAD_PROC) |=> (use_psp && !mode_handler));

endmodule

// File: tb/proc_mode_ctrl_tb.sv
module proc_mode_ctrl_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctl_wr_en = 1'b0;
   logic [1:0]  ctl_wr_data = 2'b00;
   logic        ctl_wr_priv = 1'b0;
   logic        exc_entry = 1'b0;
   logic        exc_return = 1'b0;
   logic [31:0] exc_ret_code = '0;
   logic        mode_handler, priv_eff, use_psp, ret_fault;
   logic [31:0] entry_code;

   always #5 clk = ~clk;

   proc_mode_ctrl u_dut (
      .clk(clk), .rst_n(rst_n),
      .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data), .ctl_wr_priv(ctl_wr_priv),
      .exc_entry(exc_entry), .exc_return(exc_return), .exc_ret_code(exc_ret_code),
      .mode_handler(mode_handler), .priv_eff(priv_eff), .use_psp(use_psp),
      .entry_code(entry_code), .ret_fault(ret_fault)
   );

   typedef struct {
      logic  h;
      logic  p;
      logic  s;
      logic  f;
      string tag;
   } exp_t;

   exp_t q[$];
   int   n_chk = 0;
   int   n_bad = 0;
   bit   done = 1'b0;

   int   m_nest = 0;
   logic m_b0 = 1'b0;
   logic m_b1 = 1'b0;

   task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic step(input string tag, input bit ent, input bit rt, input logic [31:0] code,
                       input bit we, input logic [1:0] wd, input bit wp);
      exp_t e;
      bit   fit;
      @(negedge clk);
      exc_entry = ent; exc_return = rt; exc_ret_code = code;
      ctl_wr_en = we; ctl_wr_data = wd; ctl_wr_priv = wp;
      #1;
      if (ent) begin
         // R7 return code offered for saving
         cmp({tag, " R7 entry_code"}, entry_code,
             (m_nest > 0) ? 32'hFFFF_FFF1 : (m_b1 ? 32'hFFFF_FFFD : 32'hFFFF_FFF9));
      end
      e.f = 1'b0;
      if (ent) begin
         if (m_nest < 15) m_nest++;
         m_b1 = 1'b0;
      end else if (rt) begin
         if (code == 32'hFFFF_FFF1)      fit = (m_nest > 1);
         else if (code == 32'hFFFF_FFF9 || code == 32'hFFFF_FFFD) fit = (m_nest == 1);
         else                            fit = 1'b0;
         if (fit) begin
            m_nest--;
            m_b1 = (code == 32'hFFFF_FFFD);
         end else begin
            e.f = 1'b1;
         end
      end else if (we && wp) begin
         m_b0 = wd[0];
         if (m_nest == 0) m_b1 = wd[1];
      end
      e.h   = (m_nest > 0);
      e.p   = e.h || !m_b0;
      e.s   = !e.h && m_b1;
      e.tag = tag;
      q.push_back(e);
   endtask

   task automatic idle(input string tag);
      step(tag, 0, 0, 32'h0, 0, 2'b00, 0);
   endtask

   initial begin : monitor
      exp_t e;
      forever begin
         @(posedge clk);
         #2;
         if (q.size() > 0) begin
            e = q.pop_front();
            cmp({e.tag, " mode"},  {31'b0, mode_handler}, {31'b0, e.h});
            cmp({e.tag, " priv"},  {31'b0, priv_eff},     {31'b0, e.p});
            cmp({e.tag, " stack"}, {31'b0, use_psp},      {31'b0, e.s});
            cmp({e.tag, " fault"}, {31'b0, ret_fault},    {31'b0, e.f});
         end
      end
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         n_chk++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : driver
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle("R1 reset state");
      // R1 entry_code straight out of reset
      #1 cmp("R1 entry_code", entry_code, 32'hFFFF_FFF9);
      step("R2 thread unpriv",      0, 0, 0, 1, 2'b01, 1);
      step("R5 unpriv write",       0, 0, 0, 1, 2'b10, 0);
      step("R5 unpriv write again", 0, 0, 0, 1, 2'b00, 0);
      step("R6 entry from thread",  1, 0, 0, 0, 2'b00, 0);
      step("R4 handler write b1",   0, 0, 0, 1, 2'b10, 1);
      idle("R4 handler stays msp");
      step("R8 return main",        0, 1, 32'hFFFF_FFF9, 0, 2'b00, 0);
      step("R3 select psp",         0, 0, 0, 1, 2'b10, 1);
      step("R6 entry from psp",     1, 0, 0, 0, 2'b00, 0);
      step("R11 nested entry",      1, 0, 0, 0, 2'b00, 0);
      step("R9 early thread ret",   0, 1, 32'hFFFF_FFF9, 0, 2'b00, 0);
      idle("R9 fault one cycle");
      step("R9 bad code",           0, 1, 32'h0000_00F9, 0, 2'b00, 0);
      step("R11 return to handler", 0, 1, 32'hFFFF_FFF1, 0, 2'b00, 0);
      step("R9 handler ret depth1", 0, 1, 32'hFFFF_FFF1, 0, 2'b00, 0);
      step("R8 return process",     0, 1, 32'hFFFF_FFFD, 0, 2'b00, 0);
      step("R9 return in thread",   0, 1, 32'hFFFF_FFFD, 0, 2'b00, 0);
      step("R2 back to priv",       0, 0, 0, 1, 2'b00, 1);
      step("R10 entry beats write", 1, 0, 0, 1, 2'b11, 1);
      step("R10 return beats write",0, 1, 32'hFFFF_FFF9, 1, 2'b11, 1);
      step("R3 psp again",          0, 0, 0, 1, 2'b11, 1);
      step("R7 entry thread psp",   1, 0, 0, 0, 2'b00, 0);
      step("R7 entry from handler", 1, 0, 0, 0, 2'b00, 0);
      idle("drain");
      idle("drain");
      @(negedge clk);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule